// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address to a physical page through a small bank of programmable block-translation entries. There are two banks of four entries: one serves instruction fetches and the other serves data accesses. An input with each request selects the bank. Every entry is a pair of words. The upper word holds an effective base, a block-length mask and two privilege-valid flags. The lower word holds a physical base and a two-bit protection code. All four entries of the selected bank are compared in parallel in a single cycle. The lowest-numbered entry that matches supplies the translation.

Blocks can range from 128 KiB up to 256 MiB. Each set bit of the length mask turns one base bit in effective-address range [27:17] into a don't-care during the compare. The same address bit is then copied straight into the physical address. Results are registered and appear one cycle after the request, marked by a valid strobe. A miss is only flagged. A page-table walk, if one is needed, belongs to another block.

Entries are written through a port that takes an index and an upper/lower select. A store to an upper word is normalised: base bits that the new mask covers are cleared in the upper word and also in the lower word of the same pair.

Top module: `blk_xlat_top`

## Requirements
- R1: After synchronous reset, rsp_valid is low and every entry of both banks is cleared, so any lookup misses.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high. The response fields stay valid until the next response.
- R3: An entry can match only when effective-address bits [31:28] equal upper-word bits [31:28].
- R4: Effective-address bits [27:17] are compared with upper-word bits [27:17] only at positions where the length mask is zero. The mask is upper-word bits [12:2], aligned to bits [27:17].
- R5: An entry is usable by supervisor requests (req_is_user=0) when upper-word bit 1 is set, and by user requests when upper-word bit 0 is set.
- R6: The physical page rsp_page holds physical address bits [31:12]. Its bits [31:28] come from lower-word bits [31:28]. Its bits [27:17] are (effective address AND mask) OR lower-word bits [27:17]. Its bits [16:12] are effective-address bits [16:12].
- R7: Lower-word bits [1:0] give the protection. If bit 1 is set, the block is read/write. If only bit 0 is set, it is read-only. If both are clear, there is no access.
- R8: When several entries match, the lowest-numbered entry wins, and its number appears on rsp_entry.
- R9: A write to an upper word stores bits [31:28], bits [12:0], and bits [27:17] with every bit covered by the new mask cleared. Bits [16:13] are stored as zero. The same covered bits are cleared in the paired lower word's base.
- R10: wr_idx bit 2 picks the bank (0 = instruction, 1 = data) and bits [1:0] pick the entry. Requests with req_is_fetch=1 look up only the instruction bank; all other requests look up only the data bank.
- R11: rsp_perm_fault is high when an entry hits but the protection does not allow the request (a write when req_is_write=1, otherwise a read).
- R12: On a miss, rsp_hit, rsp_page, rsp_entry, rsp_rd_ok, rsp_wr_ok and rsp_perm_fault are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_is_fetch | input | 1 | 1 selects the instruction bank |
| req_is_user | input | 1 | 1 for user privilege, 0 for supervisor |
| req_is_write | input | 1 | 1 for a store access |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 3 | Bank (bit 2) and entry (bits 1:0) |
| wr_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_data | input | 32 | Word to store |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | An entry matched |
| rsp_entry | output | 2 | Number of the winning entry |
| rsp_page | output | 20 | Physical address bits [31:12] |
| rsp_rd_ok | output | 1 | Reads are allowed |
| rsp_wr_ok | output | 1 | Writes are allowed |
| rsp_perm_fault | output | 1 | Hit, but the requested access is not allowed |

## Verification
The checker assumes that wr_en and req_valid are never driven X outside reset. It also assumes that a response is judged against the request from the cycle just before it. Because of that, the bench changes inputs only between edges and keeps each request one cycle long. It leaves idle cycles between requests, so every response can be tied to a single request. All entries are programmed before any lookup that depends on them. Write and lookup never share a cycle, so no result depends on a store that has just landed.

// File: rtl/blk_xlat_pkg.sv
package blk_xlat_pkg;

    localparam int EA_W   = 32;
    localparam int PAGE_W = 20;
    localparam int BASE_W = 11;
    localparam int SEG_W  = 4;

    // decoded upper word of an entry (normalised form)
    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [BASE_W-1:0] base;
        logic [BASE_W-1:0] blen;
        logic              sup_v;
        logic              usr_v;
    } bxu_upper_t;

    // decoded lower word of an entry
    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [BASE_W-1:0] base;
        logic [1:0]        pp;
    } bxu_lower_t;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2
    } bxu_perm_e;

    typedef struct packed {
        logic              hit;
        logic [PAGE_W-1:0] page;
        bxu_perm_e         perm;
    } bxu_match_t;

    // upper-word store: masked base bits are dropped
    function automatic bxu_upper_t upper_from_word(input logic [EA_W-1:0] w);
        bxu_upper_t u;
        u.seg   = w[31:28];
        u.blen  = w[12:2];
        u.base  = w[27:17] & ~w[12:2];
        u.sup_v = w[1];
        u.usr_v = w[0];
        return u;
    endfunction

    function automatic bxu_lower_t lower_from_word(input logic [EA_W-1:0] w);
        bxu_lower_t l;
        l.seg  = w[31:28];
        l.base = w[27:17];
        l.pp   = w[1:0];
        return l;
    endfunction

    function automatic bxu_perm_e pp_to_perm(input logic [1:0] pp);
        if (pp[1])      return PERM_RW;
        else if (pp[0]) return PERM_RO;
        else            return PERM_NONE;
    endfunction

endpackage

// File: rtl/bxu_regfile.sv
module bxu_regfile
    import blk_xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_set,
    input  logic [IDX_W-1:0]      wr_ent,
    input  logic                  wr_upper,
    input  logic [EA_W-1:0]       wr_data,
    output bxu_upper_t            up_o [2][NUM_ENTRIES],
    output bxu_lower_t            lo_o [2][NUM_ENTRIES]
);

    // bits [16:13] of any store and [16:2] of lower stores carry nothing kept
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[16:13];

    for (genvar s = 0; s < 2; s++) begin : g_set
        for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
            bxu_upper_t up_q;
            bxu_lower_t lo_q;
            logic       sel;

            assign sel = wr_en && (wr_set == 1'(s)) && (wr_ent == IDX_W'(e));

            always_ff @(posedge clk) begin
                if (rst) begin
                    up_q <= '0;
                    lo_q <= '0;
                end else if (sel) begin
                    if (wr_upper) begin
                        up_q         <= upper_from_word(wr_data);
                        lo_q.base    <= lo_q.base & ~wr_data[12:2];
                    end else begin
                        lo_q         <= lower_from_word(wr_data);
                    end
                end
            end

            assign up_o[s][e] = up_q;
            assign lo_o[s][e] = lo_q;
        end
    end

endmodule

// File: rtl/bxu_match.sv
module bxu_match
    import blk_xlat_pkg::*;
(
    input  bxu_upper_t        up_i,
    input  bxu_lower_t        lo_i,
    input  logic [PAGE_W-1:0] ea_page,   // effective address bits [31:12]
    input  logic              is_user,
    output bxu_match_t        m_o
);

    logic [SEG_W-1:0]  ea_seg;
    logic [BASE_W-1:0] ea_blk;
    logic [4:0]        ea_off;
    logic              seg_eq;
    logic              blk_eq;
    logic              priv_ok;

    assign ea_seg = ea_page[19:16];
    assign ea_blk = ea_page[15:5];
    assign ea_off = ea_page[4:0];

    assign seg_eq  = (ea_seg == up_i.seg);
    assign blk_eq  = ((ea_blk & ~up_i.blen) == up_i.base);
    assign priv_ok = is_user ? up_i.usr_v : up_i.sup_v;

    always_comb begin
        m_o.hit  = seg_eq && blk_eq && priv_ok;
        m_o.page = {lo_i.seg, (ea_blk & up_i.blen) | lo_i.base, ea_off};
        m_o.perm = pp_to_perm(lo_i.pp);
    end

endmodule

// File: rtl/bxu_pick.sv
module bxu_pick
    import blk_xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  bxu_match_t        m_i [NUM_ENTRIES],
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [PAGE_W-1:0] page_o,
    output bxu_perm_e         perm_o
);

    // scan from the top so the lowest matching entry is written last
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        page_o = '0;
        perm_o = PERM_NONE;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (m_i[i].hit) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(i);
                page_o = m_i[i].page;
                perm_o = m_i[i].perm;
            end
        end
    end

endmodule

// File: rtl/blk_xlat_top.sv
module blk_xlat_top
    import blk_xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic              req_is_fetch,
    input  logic              req_is_user,
    input  logic              req_is_write,
    input  logic              wr_en,
    input  logic [IDX_W:0]    wr_idx,
    input  logic              wr_upper,
    input  logic [31:0]       wr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_entry,
    output logic [19:0]       rsp_page,
    output logic              rsp_rd_ok,
    output logic              rsp_wr_ok,
    output logic              rsp_perm_fault
);

    localparam logic SET_INSN = 1'b0;
    localparam logic SET_DATA = 1'b1;

    bxu_upper_t up_all [2][NUM_ENTRIES];
    bxu_lower_t lo_all [2][NUM_ENTRIES];
    bxu_upper_t up_sel [NUM_ENTRIES];
    bxu_lower_t lo_sel [NUM_ENTRIES];
    bxu_match_t m_all  [NUM_ENTRIES];

    logic              set_sel;
    logic              pick_hit;
    logic [IDX_W-1:0]  pick_idx;
    logic [PAGE_W-1:0] pick_page;
    bxu_perm_e         pick_perm;
    logic              rd_ok_c, wr_ok_c, fault_c;

    logic unused_ea_low;
    assign unused_ea_low = ^req_ea[11:0];

    bxu_regfile #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_set   (wr_idx[IDX_W]),
        .wr_ent   (wr_idx[IDX_W-1:0]),
        .wr_upper (wr_upper),
        .wr_data  (wr_data),
        .up_o     (up_all),
        .lo_o     (lo_all)
    );

    assign set_sel = req_is_fetch ? SET_INSN : SET_DATA;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
        assign up_sel[e] = up_all[set_sel][e];
        assign lo_sel[e] = lo_all[set_sel][e];

        bxu_match u_match (
            .up_i    (up_sel[e]),
            .lo_i    (lo_sel[e]),
            .ea_page (req_ea[31:12]),
            .is_user (req_is_user),
            .m_o     (m_all[e])
        );
    end

    bxu_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .m_i    (m_all),
        .hit_o  (pick_hit),
        .idx_o  (pick_idx),
        .page_o (pick_page),
        .perm_o (pick_perm)
    );

    always_comb begin
        rd_ok_c = pick_hit && (pick_perm != PERM_NONE);
        wr_ok_c = pick_hit && (pick_perm == PERM_RW);
        fault_c = pick_hit && (req_is_write ? !wr_ok_c : !rd_ok_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_entry      <= '0;
            rsp_page       <= '0;
            rsp_rd_ok      <= 1'b0;
            rsp_wr_ok      <= 1'b0;
            rsp_perm_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit        <= pick_hit;
                rsp_entry      <= pick_idx;
                rsp_page       <= pick_page;
                rsp_rd_ok      <= rd_ok_c;
                rsp_wr_ok      <= wr_ok_c;
                rsp_perm_fault <= fault_c;
            end
        end
    end

endmodule

// File: rtl/blk_xlat_chk.sv
module blk_xlat_chk #(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [31:0]      req_ea,
    input logic             req_is_write,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_entry,
    input logic [19:0]      rsp_page,
    input logic             rsp_rd_ok,
    input logic             rsp_wr_ok,
    input logic             rsp_perm_fault
);

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_offset_passes_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_hit || rsp_page[4:0] == $past(req_ea[16:12])));

    assert_write_implies_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_wr_ok) |-> rsp_rd_ok);

    assert_fault_matches_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_perm_fault ==
            (rsp_hit && ($past(req_is_write) ? !rsp_wr_ok : !rsp_rd_ok))));

    assert_miss_clean_R12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |->
            (rsp_page == '0 && rsp_entry == '0 && !rsp_rd_ok && !rsp_wr_ok && !rsp_perm_fault));

endmodule

bind blk_xlat_top blk_xlat_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ea         (req_ea),
    .req_is_write   (req_is_write),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_entry      (rsp_entry),
    .rsp_page       (rsp_page),
    .rsp_rd_ok      (rsp_rd_ok),
    .rsp_wr_ok      (rsp_wr_ok),
    .rsp_perm_fault (rsp_perm_fault)
);

// File: tb/tb_blk_xlat_top.sv
module tb_blk_xlat_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_fetch, req_is_user, req_is_write;
    logic [31:0] req_ea;
    logic        wr_en, wr_upper;
    logic [2:0]  wr_idx;
    logic [31:0] wr_data;
    logic        rsp_valid, rsp_hit, rsp_rd_ok, rsp_wr_ok, rsp_perm_fault;
    logic [1:0]  rsp_entry;
    logic [19:0] rsp_page;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_xlat_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
        .req_is_fetch(req_is_fetch), .req_is_user(req_is_user),
        .req_is_write(req_is_write), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_upper(wr_upper), .wr_data(wr_data), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_entry(rsp_entry), .rsp_page(rsp_page),
        .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok),
        .rsp_perm_fault(rsp_perm_fault)
    );

    typedef struct packed {
        logic [31:0] ea;
        logic        fetch;
        logic        user;
        logic        wr;
        logic        hit;
        logic [1:0]  ent;
        logic [19:0] page;
        logic        rd_ok;
        logic        wr_ok;
        logic        flt;
    } vec_t;

    // data bank: e0 sup rw, e1 1MiB both ro, e2 user rw, e3 sup ro (shadowed by e0)
    // insn bank: e0 both privileges, no access
    localparam vec_t VECS [NVEC] = '{
        '{32'h1000_4000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 20'h80004, 1'b1, 1'b1, 1'b0}, // R8 R5
        '{32'h1000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 20'h70004, 1'b1, 1'b1, 1'b0}, // R5 R8
        '{32'h203A_5000, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 20'h9ABA5, 1'b1, 1'b0, 1'b0}, // R4 R6 R9
        '{32'h203A_5000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 20'h9ABA5, 1'b1, 1'b0, 1'b1}, // R11 R7
        '{32'h2050_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 20'h00000, 1'b0, 1'b0, 1'b0}, // R4 R12
        '{32'h3000_4000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 20'h00000, 1'b0, 1'b0, 1'b0}, // R3
        '{32'h1002_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 20'h00000, 1'b0, 1'b0, 1'b0}, // R4
        '{32'h1000_4000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 20'h40004, 1'b0, 1'b0, 1'b1}, // R10 R7
        '{32'h203A_5000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 20'h00000, 1'b0, 1'b0, 1'b0}, // R10
        '{32'h1000_4000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 20'h80004, 1'b1, 1'b1, 1'b0}  // R7 R11
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic up, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_upper = up; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] ea, input logic f, input logic u, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_is_fetch = f; req_is_user = u; req_is_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic show_summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            show_summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_ea = '0; req_is_fetch = 1'b0;
        req_is_user = 1'b0; req_is_write = 1'b0;
        wr_en = 1'b0; wr_idx = '0; wr_upper = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;

        // R1: cleared entries miss
        lookup(32'h1000_4000, 1'b0, 1'b0, 1'b0);
        chk("R1", "valid after reset lookup", 32'(rsp_valid), 32'd1);
        chk("R1", "hit after reset", 32'(rsp_hit), 32'd0);
        @(negedge clk);
        chk("R2", "valid drops when idle", 32'(rsp_valid), 32'd0);

        // data bank (wr_idx bit2 = 1), lower before upper
        wr_reg(3'd4, 1'b0, 32'h8000_0002);
        wr_reg(3'd4, 1'b1, 32'h1000_0002);
        wr_reg(3'd5, 1'b0, 32'h9ABE_0001);
        wr_reg(3'd5, 1'b1, 32'h203E_001F);  // R9: mask clears bits 19:17 of both words
        wr_reg(3'd6, 1'b0, 32'h7000_0003);
        wr_reg(3'd6, 1'b1, 32'h1000_0001);
        wr_reg(3'd7, 1'b0, 32'h6000_0001);
        wr_reg(3'd7, 1'b1, 32'h1000_0002);
        // instruction bank entry 0
        wr_reg(3'd0, 1'b0, 32'h4000_0000);
        wr_reg(3'd0, 1'b1, 32'h1000_0003);

        for (int i = 0; i < NVEC; i++) begin
            lookup(VECS[i].ea, VECS[i].fetch, VECS[i].user, VECS[i].wr);
            chk("R2", $sformatf("vec%0d valid", i), 32'(rsp_valid), 32'd1);
            chk("R3/R4/R5", $sformatf("vec%0d hit", i), 32'(rsp_hit), 32'(VECS[i].hit));
            chk("R8", $sformatf("vec%0d entry", i), 32'(rsp_entry), 32'(VECS[i].ent));
            chk("R6", $sformatf("vec%0d page", i), 32'(rsp_page), 32'(VECS[i].page));
            chk("R7", $sformatf("vec%0d rd_ok", i), 32'(rsp_rd_ok), 32'(VECS[i].rd_ok));
            chk("R7", $sformatf("vec%0d wr_ok", i), 32'(rsp_wr_ok), 32'(VECS[i].wr_ok));
            chk("R11", $sformatf("vec%0d fault", i), 32'(rsp_perm_fault), 32'(VECS[i].flt));
        end

        // R9: rewrite data entry 1 with a 2MiB mask; lower base bit 20 also cleared
        wr_reg(3'd5, 1'b0, 32'h9AB0_0002);
        wr_reg(3'd5, 1'b1, 32'h2030_003F);
        lookup(32'h203A_5000, 1'b0, 1'b0, 1'b0);
        chk("R9", "remasked hit", 32'(rsp_hit), 32'd1);
        chk("R9", "remasked page", 32'(rsp_page), 32'h9ABA5);
        chk("R7", "remasked wr_ok", 32'(rsp_wr_ok), 32'd1);

        // R12: miss after a hit leaves fields zero
        lookup(32'hF000_0000, 1'b0, 1'b0, 1'b1);
        chk("R12", "miss page", 32'(rsp_page), 32'd0);
        chk("R12", "miss fault", 32'(rsp_perm_fault), 32'd0);

        // R1: reset again clears the entries
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        lookup(32'h1000_4000, 1'b0, 1'b0, 1'b0);
        chk("R1", "hit after second reset", 32'(rsp_hit), 32'd0);

        done = 1'b1;
        show_summary();
        $finish;
    end

endmodule